// File: doc/BRIEF.md
# Decryption Region Configuration and Key-Lock Register Block

This block holds the software-visible settings of one memory-decryption region. Software writes it over a simple single-cycle bus with an address, a write enable, write data and combinational read data. The block stores:

- an enable bit and a two-bit access-mode field;
- a 16-bit firmware version field;
- the region's start address, end address and two nonce words;
- four 32-bit key words.

It exports the live enable, mode, enhanced-mode flag and 128-bit key to the keystream and XOR datapath, which lie outside this block.

Two set-once lock bits protect the contents until block reset. The configuration lock freezes the configuration, version, address and nonce registers, and setting it also sets the key lock. The key lock freezes the key words and their checksum. Locked writes are dropped without any response.

While the key words are written, hardware accumulates a CRC-8 over them. The CRC runs only over a strictly ordered sequence of writes to word 0, 1, 2 and then 3. The checksum reads zero until that sequence completes. Any write that changes the mode wipes the key and the checksum.

Top module: `xdec_region_regs`

## Requirements

- R1: After reset, every readable address returns 0 and `region_en`, `region_mode`, `region_enhanced` and `region_key` are all 0.
- R2: A write to the control word (address 0) while the configuration lock is clear loads enable from bit 0 and mode from bits 2:1. Mode 00 selects instruction fetches only, 01 data reads only, 10 all reads, and 11 instruction fetches with enhanced mode. `region_enhanced` is 1 exactly when the mode is 11. The control word reads back enable, mode, key lock on bit 3, configuration lock on bit 4 and the checksum on bits 15:8.
- R3: Writing 1 to control bit 4 sets the configuration lock. The lock then clears only on reset. While it is set, writes to the control word, version (address 1), start address (2), end address (3) and nonce words (4 and 5) have no effect.
- R4: Writing 1 to control bit 3 sets the key lock, and writing 1 to bit 4 also sets it. Writing 0 to either bit never clears a lock; only reset clears them.
- R5: While the key lock is set, writes to the key words (addresses 8 to 11) change neither `region_key` nor the checksum.
- R6: An accepted control write whose bits 2:1 differ from the current mode clears all four key words and the checksum to 0, whether or not the key lock is set. A control write that keeps the mode leaves the key intact.
- R7: After accepted writes to key word 0, 1, 2 and 3 in that order, each written once, the checksum equals CRC-8 with polynomial 0x07 and initial value 0x00. The CRC runs over the 128 bits with word 0 first and each word MSB first. The result is visible on the cycle after the word-3 write.
- R8: The checksum reads 0 from the cycle after a key word 0 write until that sequence completes.
- R9: A key write other than the next expected word aborts the sequence and leaves the checksum at 0. A repeated word also counts as unexpected. Later in-order writes do not resume the aborted sequence; only a new word-0 write starts one.
- R10: Key word N is written at address 8+N and appears on `region_key[32N+31:32N]`. Key addresses read back as 0. Bus writes to control bits 15:8 do not change the checksum.
- R11: Version (low 16 bits of address 1), start address, end address and both nonce words read back the last value accepted for them.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| region_en | output | 1 | Region decryption enable |
| region_mode | output | 2 | Access-mode field |
| region_enhanced | output | 1 | Enhanced mode active (mode 11) |
| region_key | output | 128 | Key words, word 0 in the low 32 bits |

## Verification

Every stored value, lock bit, key word and checksum changes at the clock edge that accepts the write. Read data is combinational on the address, so each result is due one edge after its stimulus. The bench drives the bus on the falling edge and holds each write for exactly one rising edge. It then samples outputs and read data shortly after the next falling edge, so every check falls in the first cycle where the new value is due. The checksum is also read between the key writes of a sequence, which catches both a result published too early and a result left over from an earlier sequence.

// File: rtl/xdec_pkg.sv
package xdec_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int KEY_WORDS   = 4;
    localparam int NONCE_WORDS = 2;
    localparam int VER_W       = 16;
    localparam int CRC_W       = 8;
    localparam int MODE_W      = 2;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    localparam int KEY_IDX_W   = $clog2(KEY_WORDS);
    localparam int NONCE_IDX_W = (NONCE_WORDS > 1) ? $clog2(NONCE_WORDS) : 1;
    localparam int KEY_FLAT_W  = KEY_WORDS * DATA_W;

    // word addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] A_VER    = 4'h1;
    localparam logic [ADDR_W-1:0] A_START  = 4'h2;
    localparam logic [ADDR_W-1:0] A_END    = 4'h3;
    localparam logic [ADDR_W-1:0] A_NONCE0 = 4'h4;
    localparam logic [ADDR_W-1:0] A_KEY0   = 4'h8;

    // control word bit positions
    localparam int B_EN     = 0;
    localparam int B_MODE   = 1;
    localparam int B_KLOCK  = 3;
    localparam int B_CLOCK  = 4;
    localparam int B_CRC    = 8;

    typedef enum logic [MODE_W-1:0] {
        MODE_FETCH     = 2'b00,
        MODE_DATA      = 2'b01,
        MODE_ALL       = 2'b10,
        MODE_FETCH_ENH = 2'b11
    } mode_e;

    typedef struct packed {
        logic                                en;
        logic [MODE_W-1:0]                   mode;
        logic                                klock;
        logic                                clock;
        logic [VER_W-1:0]                    ver;
        logic [DATA_W-1:0]                   start_addr;
        logic [DATA_W-1:0]                   end_addr;
        logic [NONCE_WORDS-1:0][DATA_W-1:0]  nonce;
    } ctrl_state_t;
endpackage

// File: rtl/xdec_crc8_word.sv
// One full data word folded into the running CRC in a single cycle, MSB first.
module xdec_crc8_word #(
    parameter int               DW   = 32,
    parameter int               CW   = 8,
    parameter logic [CW-1:0]    POLY = 8'h07
) (
    input  logic [CW-1:0] crc_in,
    input  logic [DW-1:0] data,
    output logic [CW-1:0] crc_out
);
    logic [CW-1:0] stage [DW+1];

    assign stage[0] = crc_in;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic fb;
        assign fb           = stage[b][CW-1] ^ data[DW-1-b];
        assign stage[b+1]   = {stage[b][CW-2:0], 1'b0} ^ (fb ? POLY : {CW{1'b0}});
    end

    assign crc_out = stage[DW];
endmodule

// File: rtl/xdec_key_seq.sv
// Tracks the ordered key-write sequence and publishes the checksum on completion.
module xdec_key_seq
    import xdec_pkg::*;
#(
    parameter int NW = KEY_WORDS,
    parameter int DW = DATA_W,
    parameter int CW = CRC_W,
    parameter int IW = KEY_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          wipe,
    output logic [CW-1:0] crc_pub
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NW - 1);

    typedef struct packed {
        logic          active;
        logic [IW-1:0] next_idx;
        logic [CW-1:0] acc;
        logic [CW-1:0] pub;
    } seq_t;

    seq_t s_d, s_q;
    logic [CW-1:0] crc_seed;
    logic [CW-1:0] crc_step;

    assign crc_seed = (wr_idx == '0) ? '0 : s_q.acc;

    xdec_crc8_word #(.DW(DW), .CW(CW), .POLY(CRC_POLY)) u_crc (
        .crc_in  (crc_seed),
        .data    (wr_data),
        .crc_out (crc_step)
    );

    always_comb begin
        s_d = s_q;
        if (wipe) begin
            s_d = '0;
        end else if (wr_en) begin
            if (wr_idx == '0) begin
                s_d.active   = 1'b1;
                s_d.next_idx = IW'(1);
                s_d.acc      = crc_step;
                s_d.pub      = '0;
            end else if (s_q.active && (wr_idx == s_q.next_idx)) begin
                s_d.acc = crc_step;
                if (wr_idx == LAST_IDX) begin
                    s_d.active   = 1'b0;
                    s_d.next_idx = '0;
                    s_d.pub      = crc_step;
                end else begin
                    s_d.next_idx = s_q.next_idx + IW'(1);
                    s_d.pub      = '0;
                end
            end else begin
                s_d.active   = 1'b0;
                s_d.next_idx = '0;
                s_d.pub      = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign crc_pub = s_q.pub;
endmodule

// File: rtl/xdec_key_bank.sv
// Storage for the key words with a whole-bank wipe.
module xdec_key_bank
    import xdec_pkg::*;
#(
    parameter int NW = KEY_WORDS,
    parameter int DW = DATA_W,
    parameter int IW = KEY_IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [DW-1:0]          wr_data,
    input  logic                   wipe,
    output logic [NW-1:0][DW-1:0]  key
);
    logic [NW-1:0][DW-1:0] key_d, key_q;

    for (genvar w = 0; w < NW; w++) begin : g_word
        always_comb begin
            key_d[w] = key_q[w];
            if (wipe)
                key_d[w] = '0;
            else if (wr_en && (wr_idx == IW'(w)))
                key_d[w] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= '0;
        else        key_q <= key_d;
    end

    assign key = key_q;
endmodule

// File: rtl/xdec_region_regs.sv
// Region configuration registers with set-once locks and key checksum.
module xdec_region_regs
    import xdec_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    region_en,
    output logic [MODE_W-1:0]       region_mode,
    output logic                    region_enhanced,
    output logic [KEY_FLAT_W-1:0]   region_key
);
    ctrl_state_t c_d, c_q;

    logic                          key_hit;
    logic                          key_wr;
    logic [KEY_IDX_W-1:0]          key_idx;
    logic                          nonce_hit;
    logic [NONCE_IDX_W-1:0]        nonce_idx;
    logic                          ctrl_wr;
    logic                          mode_wipe;
    logic [CRC_W-1:0]              crc_pub;
    logic [KEY_WORDS-1:0][DATA_W-1:0] key_words;
    logic                          cfg_lock;
    logic                          key_lock;

    // address decode
    assign key_hit   = (bus_addr[ADDR_W-1:KEY_IDX_W] == A_KEY0[ADDR_W-1:KEY_IDX_W]);
    assign key_idx   = bus_addr[KEY_IDX_W-1:0];
    assign key_wr    = bus_we && key_hit && !c_q.klock;
    assign nonce_hit = (int'(bus_addr) >= int'(A_NONCE0)) &&
                       (int'(bus_addr) <  int'(A_NONCE0) + NONCE_WORDS);
    assign nonce_idx = NONCE_IDX_W'(bus_addr - A_NONCE0);
    assign ctrl_wr   = bus_we && (bus_addr == A_CTRL) && !c_q.clock;
    assign mode_wipe = ctrl_wr && (bus_wdata[B_MODE +: MODE_W] != c_q.mode);

    always_comb begin
        c_d = c_q;
        if (bus_we && !c_q.clock) begin
            if (bus_addr == A_CTRL) begin
                c_d.en    = bus_wdata[B_EN];
                c_d.mode  = bus_wdata[B_MODE +: MODE_W];
                c_d.clock = bus_wdata[B_CLOCK];
                c_d.klock = c_q.klock | bus_wdata[B_KLOCK] | bus_wdata[B_CLOCK];
            end else if (bus_addr == A_VER) begin
                c_d.ver = bus_wdata[VER_W-1:0];
            end else if (bus_addr == A_START) begin
                c_d.start_addr = bus_wdata;
            end else if (bus_addr == A_END) begin
                c_d.end_addr = bus_wdata;
            end else if (nonce_hit) begin
                c_d.nonce[nonce_idx] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    xdec_key_bank #(.NW(KEY_WORDS), .DW(DATA_W), .IW(KEY_IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (key_wr),
        .wr_idx  (key_idx),
        .wr_data (bus_wdata),
        .wipe    (mode_wipe),
        .key     (key_words)
    );

    xdec_key_seq #(.NW(KEY_WORDS), .DW(DATA_W), .CW(CRC_W), .IW(KEY_IDX_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (key_wr),
        .wr_idx  (key_idx),
        .wr_data (bus_wdata),
        .wipe    (mode_wipe),
        .crc_pub (crc_pub)
    );

    // read mux; key words are write-only
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_EN]              = c_q.en;
                bus_rdata[B_MODE +: MODE_W]  = c_q.mode;
                bus_rdata[B_KLOCK]           = c_q.klock;
                bus_rdata[B_CLOCK]           = c_q.clock;
                bus_rdata[B_CRC +: CRC_W]    = crc_pub;
            end
            A_VER:   bus_rdata[VER_W-1:0] = c_q.ver;
            A_START: bus_rdata = c_q.start_addr;
            A_END:   bus_rdata = c_q.end_addr;
            default: begin
                if (nonce_hit) bus_rdata = c_q.nonce[nonce_idx];
            end
        endcase
    end

    assign cfg_lock        = c_q.clock;
    assign key_lock        = c_q.klock;
    assign region_en       = c_q.en;
    assign region_mode     = c_q.mode;
    assign region_enhanced = (c_q.mode == MODE_FETCH_ENH);
    assign region_key      = key_words;
endmodule

// File: rtl/xdec_region_regs_chk.sv
module xdec_region_regs_chk
    import xdec_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_we,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic                  region_en,
    input logic [MODE_W-1:0]     region_mode,
    input logic [KEY_FLAT_W-1:0] region_key,
    input logic                  cfg_lock,
    input logic                  key_lock,
    input logic [CRC_W-1:0]      crc_pub
);
    logic key_addr;
    assign key_addr = (bus_addr[ADDR_W-1:KEY_IDX_W] == A_KEY0[ADDR_W-1:KEY_IDX_W]);

    a_r3_cfg_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> cfg_lock);

    a_r3_locked_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lock && bus_we && bus_addr == A_CTRL) |=> ($stable(region_en) && $stable(region_mode)));

    a_r4_key_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        key_lock |=> key_lock);

    a_r4_cfg_implies_key: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |-> key_lock);

    a_r5_locked_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (key_lock && bus_we && key_addr) |=> ($stable(region_key) && $stable(crc_pub)));

    a_r6_mode_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_lock && bus_we && bus_addr == A_CTRL && bus_wdata[B_MODE +: MODE_W] != region_mode)
        |=> (region_key == '0 && crc_pub == '0));

    a_r8_start_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_lock && bus_we && bus_addr == A_KEY0) |=> (crc_pub == '0));
endmodule

bind xdec_region_regs xdec_region_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .region_en   (region_en),
    .region_mode (region_mode),
    .region_key  (region_key),
    .cfg_lock    (cfg_lock),
    .key_lock    (key_lock),
    .crc_pub     (crc_pub)
);

// File: tb/tb_xdec_region_regs.sv
module tb_xdec_region_regs;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         region_en;
    logic [1:0]   region_mode;
    logic         region_enhanced;
    logic [127:0] region_key;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xdec_region_regs dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_addr        (bus_addr),
        .bus_we          (bus_we),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .region_en       (region_en),
        .region_mode     (region_mode),
        .region_enhanced (region_enhanced),
        .region_key      (region_key)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_crc(output logic [7:0] c);
        logic [31:0] v;
        rd(4'h0, v);
        c = v[15:8];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // polynomial long division of the 128-bit message times x^8 by x^8+x^2+x+1
    function automatic logic [7:0] ref_crc(input logic [31:0] k0, k1, k2, k3);
        logic [135:0] r;
        r = {k0, k1, k2, k3, 8'h00};
        for (int i = 135; i >= 8; i--)
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        return r[7:0];
    endfunction

    function automatic logic [31:0] pat(input int t, input int i);
        return (32'h9E3779B9 * (t * 4 + i + 1)) ^ (32'hC3A5_0F1E << (i * 3 + t));
    endfunction

    task automatic load_key(input logic [31:0] k0, k1, k2, k3);
        wr(4'h8, k0); wr(4'h9, k1); wr(4'hA, k2); wr(4'hB, k3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  c;
        logic [31:0] k [4];
        logic [7:0]  good_crc;

        do_reset();

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            check($sformatf("R1 read addr %0d", a), 128'(v), 128'h0);
        end
        check("R1 region_en", 128'(region_en), 0);
        check("R1 region_mode", 128'(region_mode), 0);
        check("R1 region_enhanced", 128'(region_enhanced), 0);
        check("R1 region_key", region_key, 0);

        // R2: mode/enable sweep
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                wr(4'h0, 32'(m * 2 + e));
                check("R2 region_en", 128'(region_en), 128'(e));
                check("R2 region_mode", 128'(region_mode), 128'(m));
                check("R2 region_enhanced", 128'(region_enhanced), 128'(m == 3));
                rd(4'h0, v);
                check("R2 ctrl readback", 128'(v), 128'(m * 2 + e));
            end
        end
        wr(4'h0, 32'h0000_0002); // mode 01, disabled

        // R7/R8/R10: ordered key sequences
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < 4; i++) k[i] = pat(t, i);
            for (int i = 0; i < 4; i++) begin
                wr(4'(8 + i), k[i]);
                rd_crc(c);
                if (i < 3) check($sformatf("R8 crc mid-seq t=%0d w=%0d", t, i), 128'(c), 0);
                else       check($sformatf("R7 crc t=%0d", t), 128'(c), 128'(ref_crc(k[0], k[1], k[2], k[3])));
            end
            check("R10 key out", region_key, {k[3], k[2], k[1], k[0]});
            for (int i = 0; i < 4; i++) begin
                rd(4'(8 + i), v);
                check("R10 key reads zero", 128'(v), 0);
            end
        end

        // R9: aborted sequences
        for (int p = 1; p < 4; p++) begin
            for (int w = 1; w < 4; w++) begin
                if (w == p) continue;
                for (int i = 0; i < 4; i++) k[i] = pat(p + 10, i + w);
                for (int i = 0; i < p; i++) wr(4'(8 + i), k[i]);
                wr(4'(8 + w), 32'hDEAD_0000 + 32'(w));
                rd_crc(c);
                check($sformatf("R9 abort p=%0d w=%0d", p, w), 128'(c), 0);
                for (int i = p; i < 4; i++) wr(4'(8 + i), k[i]);
                rd_crc(c);
                check($sformatf("R9 no resume p=%0d w=%0d", p, w), 128'(c), 0);
            end
        end
        // R9: repeated word
        load_key(pat(3, 0), pat(3, 1), pat(3, 2), pat(3, 3));
        wr(4'h8, pat(4, 0)); wr(4'h9, pat(4, 1)); wr(4'h9, pat(4, 1));
        wr(4'hA, pat(4, 2)); wr(4'hB, pat(4, 3));
        rd_crc(c);
        check("R9 repeated word", 128'(c), 0);
        // R9: lone later-word write after completed sequence
        load_key(pat(5, 0), pat(5, 1), pat(5, 2), pat(5, 3));
        wr(4'hA, 32'h1234_5678);
        rd_crc(c);
        check("R9 lone write clears", 128'(c), 0);

        // R10: checksum field not writable; R6 same-mode keeps key
        for (int i = 0; i < 4; i++) k[i] = pat(7, i + 2);
        load_key(k[0], k[1], k[2], k[3]);
        good_crc = ref_crc(k[0], k[1], k[2], k[3]);
        wr(4'h0, 32'h0000_FF02);
        rd_crc(c);
        check("R10 crc write ignored", 128'(c), 128'(good_crc));
        check("R6 same mode keeps key", region_key, {k[3], k[2], k[1], k[0]});

        // R6: mode change wipes
        wr(4'h0, 32'h0000_0004);
        check("R6 wipe key", region_key, 0);
        rd_crc(c);
        check("R6 wipe crc", 128'(c), 0);

        // R11: storage readback
        wr(4'h1, 32'hABCD_1234); rd(4'h1, v); check("R11 version", 128'(v), 128'h1234);
        wr(4'h2, 32'h0800_1000); rd(4'h2, v); check("R11 start", 128'(v), 128'h0800_1000);
        wr(4'h3, 32'h0800_1FFF); rd(4'h3, v); check("R11 end", 128'(v), 128'h0800_1FFF);
        wr(4'h4, 32'h5555_AAAA); wr(4'h5, 32'h0F0F_F0F0);
        rd(4'h4, v); check("R11 nonce0", 128'(v), 128'h5555_AAAA);
        rd(4'h5, v); check("R11 nonce1", 128'(v), 128'h0F0F_F0F0);

        // R4/R5: key lock
        for (int i = 0; i < 4; i++) k[i] = pat(9, i);
        load_key(k[0], k[1], k[2], k[3]);
        good_crc = ref_crc(k[0], k[1], k[2], k[3]);
        wr(4'h0, 32'h0000_000C); // mode 10, key lock
        rd(4'h0, v);
        check("R4 key lock set", 128'(v[3]), 1);
        for (int i = 0; i < 4; i++) wr(4'(8 + i), ~k[i]);
        check("R5 key held", region_key, {k[3], k[2], k[1], k[0]});
        rd_crc(c);
        check("R5 crc held", 128'(c), 128'(good_crc));
        wr(4'h0, 32'h0000_0005); // mode 10, clear attempt
        rd(4'h0, v);
        check("R4 key lock sticky", 128'(v[3]), 1);
        check("R2 en under key lock", 128'(region_en), 1);

        // R3/R4: config lock
        do_reset();
        wr(4'h1, 32'h0000_00AA);
        wr(4'h0, 32'h0000_0017); // en, mode 11, cfg lock
        rd(4'h0, v);
        check("R4 cfg lock forces key lock", 128'(v[4:3]), 128'h3);
        wr(4'h0, 32'h0000_0000);
        check("R3 en held", 128'(region_en), 1);
        check("R3 mode held", 128'(region_mode), 3);
        rd(4'h0, v);
        check("R3 cfg lock sticky", 128'(v[4]), 1);
        wr(4'h1, 32'h0000_5555); rd(4'h1, v); check("R3 version held", 128'(v), 128'hAA);
        wr(4'h2, 32'hFFFF_FFFF); rd(4'h2, v); check("R3 start held", 128'(v), 0);
        wr(4'h3, 32'hFFFF_FFFF); rd(4'h3, v); check("R3 end held", 128'(v), 0);
        wr(4'h5, 32'hFFFF_FFFF); rd(4'h5, v); check("R3 nonce held", 128'(v), 0);
        wr(4'h8, 32'hFFFF_FFFF);
        check("R5 key held under cfg lock", region_key, 0);

        // R3/R4: reset releases locks
        do_reset();
        rd(4'h0, v);
        check("R3 locks cleared by reset", 128'(v), 0);
        wr(4'h2, 32'h0000_0040); rd(4'h2, v);
        check("R11 write after unlock", 128'(v), 128'h40);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule